// File: doc/BRIEF.md
# Dual-Port Audio Interrupt Controller

This block is the shared control point for two audio ports, each of which has an output direction and an input direction. The four per-direction service requests come in as level signals. Each request is latched into a sticky status word. Each latched bit passes through two enable masks, and the result is merged into one interrupt line for the host. The same register window also holds the clock-run bits for the two ports, a per-direction mute word, and a soft reset register. The soft reset register carries the core run bit and a four-bit port reset field.

Software reaches the block through a plain register bus. The window has six word registers starting at 0x200, and any access outside that window is dropped. A latched request can be retired in two ways. The first is a write to the status register: every bit written as 0 is cleared. The second is a low-then-high sequence on bit 4 of the soft reset register, which wipes the whole status word. The FIFOs and serial engines are outside this block. They are seen only as the request inputs and as the clock, mute and reset outputs.

Top module: `aud_icu`

## Requirements
- R1: After reset the status word, both masks, the mute word, the clock-run bits and the soft reset register are all zero. As a result `irq_o`, `clk_run`, `core_run`, `port_rst_ctl` and `mute_o` are all low.
- R2: Sources map to status bits as follows: `req_i[0]` (port A out) to bit 0, `req_i[1]` (port A in) to bit 4, `req_i[2]` (port B out) to bit 8 and `req_i[3]` (port B in) to bit 12. A source that is high at a clock edge sets its bit at that edge, and the bit stays set after the request drops.
- R3: `irq_o` is high exactly when some status bit is set and the same bit position is also set in both enable registers (offsets 0x204 and 0x208). A bit set in only one enable register does not raise the line.
- R4: A write to the status register (0x200) clears each status bit written as 0 and keeps each bit written as 1, so writing zero clears the whole word. A request that is high in the same cycle as the write wins, and its bit stays set.
- R5: A write to the soft reset register (0x214) with bit 4 set, while the stored bit 4 is 0, clears the whole status word. A write with bit 4 set while the stored bit 4 is already 1 leaves the status word untouched.
- R6: In the clock register (0x210), bit 0 drives `clk_run[0]` (port A) and bit 4 drives `clk_run[1]` (port B), one cycle after the write.
- R7: In the soft reset register, bit 0 drives `core_run`, and bits [7:4] drive `port_rst_ctl[3:0]`, with bit 4 driving `port_rst_ctl[0]`.
- R8: An access is ignored if its address lies outside 0x200 to 0x214 (word-aligned, six registers). Such a write changes no register, and such a read returns zero.
- R9: `bus_rdata` takes its new value on the clock edge that samples `bus_rd` and holds that value until the next read.
- R10: The mute register (0x20C) keeps bits 0, 4, 8 and 12, which drive `mute_o[0..3]` in the same source order as R2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_addr | input | 12 | Byte address of the register access |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_rd | input | 1 | Read strobe, one cycle per read |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, registered |
| req_i | input | 4 | Level service requests: A out, A in, B out, B in |
| irq_o | output | 1 | Merged interrupt |
| clk_run | output | 2 | Clock release for port A (bit 0) and port B (bit 1) |
| core_run | output | 1 | Core soft reset release |
| port_rst_ctl | output | 4 | Port reset control field |
| mute_o | output | 4 | Per-direction mute |

## Verification
The assertions check four things on every cycle. First, a high request always appears in the status word on the next cycle. Second, the interrupt line never rises unless a status bit and both enables are present. Third, a soft reset write whose bit 4 moves from 0 to 1 empties the status word. Fourth, writes to the clock register, and any write outside the window, leave the outputs as the requirements say. Some behaviours can only be shown by the scenarios: partial clears through a status write, a request racing a clear, the second bit-4 write that must not acknowledge, the exact read-back encodings, and read data that stays put between reads.

// File: rtl/aud_icu_pkg.sv
package aud_icu_pkg;

  // Word index of each register inside the window (offset / 4).
  typedef enum logic [2:0] {
    REG_STAT = 3'd0,
    REG_EN1  = 3'd1,
    REG_EN2  = 3'd2,
    REG_MUTE = 3'd3,
    REG_CLK  = 3'd4,
    REG_SOFT = 3'd5
  } reg_idx_e;

  localparam int unsigned N_REG = 6;
  localparam int unsigned IDX_W = 3;

endpackage

// File: rtl/aud_icu_decode.sv
module aud_icu_decode
  import aud_icu_pkg::*;
#(
  parameter int unsigned ADDR_W   = 12,
  parameter logic [11:0] WIN_BASE = 12'h200
) (
  input  logic [ADDR_W-1:0] addr,
  output logic              hit,
  output logic [IDX_W-1:0]  idx,
  output logic [N_REG-1:0]  sel
);

  localparam int unsigned WIN_LSB = IDX_W + 2;

  logic base_ok;
  logic align_ok;
  logic range_ok;

  assign base_ok  = (addr[ADDR_W-1:WIN_LSB] == WIN_BASE[ADDR_W-1:WIN_LSB]);
  assign align_ok = (addr[1:0] == 2'b00);
  assign idx      = addr[WIN_LSB-1:2];
  assign range_ok = (32'(idx) < N_REG);
  assign hit      = base_ok && align_ok && range_ok;

  for (genvar r = 0; r < N_REG; r++) begin : g_sel
    assign sel[r] = hit && (32'(idx) == r);
  end

endmodule

// File: rtl/aud_icu_field.sv
module aud_icu_field #(
  parameter int unsigned W = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    q <= '0;
    else if (load) q <= d;
  end

endmodule

// File: rtl/aud_icu_status.sv
module aud_icu_status #(
  parameter int unsigned N_SRC = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [N_SRC-1:0] req,
  input  logic             wr,
  input  logic [N_SRC-1:0] keep,
  input  logic             ack,
  output logic [N_SRC-1:0] st
);

  logic [N_SRC-1:0] keep_mask;
  logic [N_SRC-1:0] st_nxt;

  always_comb begin
    keep_mask = '1;
    if (wr)  keep_mask = keep_mask & keep;
    if (ack) keep_mask = '0;
    // Requests are applied last so they win against any clear.
    st_nxt = (st & keep_mask) | req;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st <= '0;
    else        st <= st_nxt;
  end

endmodule

// File: rtl/aud_icu_merge.sv
module aud_icu_merge #(
  parameter int unsigned N_SRC = 4
) (
  input  logic [N_SRC-1:0] st,
  input  logic [N_SRC-1:0] en_a,
  input  logic [N_SRC-1:0] en_b,
  output logic             irq
);

  logic [N_SRC-1:0] live;

  for (genvar k = 0; k < N_SRC; k++) begin : g_live
    assign live[k] = st[k] & en_a[k] & en_b[k];
  end

  assign irq = |live;

endmodule

// File: rtl/aud_icu.sv
module aud_icu
  import aud_icu_pkg::*;
#(
  parameter int unsigned ADDR_W     = 12,
  parameter int unsigned DATA_W     = 32,
  parameter int unsigned N_SRC      = 4,
  parameter int unsigned SRC_STRIDE = 4,
  parameter int unsigned N_CLK      = 2,
  parameter int unsigned CLK_STRIDE = 4,
  parameter int unsigned RST_LSB    = 4,
  parameter int unsigned RST_W      = 4,
  parameter logic [11:0] WIN_BASE   = 12'h200
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic [N_SRC-1:0]  req_i,
  output logic              irq_o,
  output logic [N_CLK-1:0]  clk_run,
  output logic              core_run,
  output logic [RST_W-1:0]  port_rst_ctl,
  output logic [N_SRC-1:0]  mute_o
);

  logic             hit;
  logic [IDX_W-1:0] idx;
  logic [N_REG-1:0] sel;
  logic [N_REG-1:0] wsel;

  logic [N_SRC-1:0] src_bits;
  logic [N_CLK-1:0] clk_bits;
  logic [N_SRC-1:0] st_q;
  logic [N_SRC-1:0] m1_q;
  logic [N_SRC-1:0] m2_q;
  logic [N_SRC-1:0] mute_q;
  logic [N_CLK-1:0] clk_q;
  logic             core_q;
  logic [RST_W-1:0] soft_q;
  logic             ack;
  logic [DATA_W-1:0] rd_word;

  aud_icu_decode #(
    .ADDR_W  (ADDR_W),
    .WIN_BASE(WIN_BASE)
  ) u_dec (
    .addr(bus_addr),
    .hit (hit),
    .idx (idx),
    .sel (sel)
  );

  assign wsel = sel & {N_REG{bus_wr}};

  // Gather strided fields from the write word.
  for (genvar k = 0; k < N_SRC; k++) begin : g_src_bits
    assign src_bits[k] = bus_wdata[k*SRC_STRIDE];
  end
  for (genvar c = 0; c < N_CLK; c++) begin : g_clk_bits
    assign clk_bits[c] = bus_wdata[c*CLK_STRIDE];
  end

  // A 0 -> 1 move of the lowest port reset bit acknowledges.
  assign ack = wsel[REG_SOFT] & bus_wdata[RST_LSB] & ~soft_q[0];

  aud_icu_status #(.N_SRC(N_SRC)) u_stat (
    .clk  (clk),
    .rst_n(rst_n),
    .req  (req_i),
    .wr   (wsel[REG_STAT]),
    .keep (src_bits),
    .ack  (ack),
    .st   (st_q)
  );

  aud_icu_field #(.W(N_SRC)) u_en1 (
    .clk(clk), .rst_n(rst_n), .load(wsel[REG_EN1]), .d(src_bits), .q(m1_q)
  );
  aud_icu_field #(.W(N_SRC)) u_en2 (
    .clk(clk), .rst_n(rst_n), .load(wsel[REG_EN2]), .d(src_bits), .q(m2_q)
  );
  aud_icu_field #(.W(N_SRC)) u_mute (
    .clk(clk), .rst_n(rst_n), .load(wsel[REG_MUTE]), .d(src_bits), .q(mute_q)
  );
  aud_icu_field #(.W(N_CLK)) u_clk (
    .clk(clk), .rst_n(rst_n), .load(wsel[REG_CLK]), .d(clk_bits), .q(clk_q)
  );
  aud_icu_field #(.W(1)) u_core (
    .clk(clk), .rst_n(rst_n), .load(wsel[REG_SOFT]), .d(bus_wdata[0]), .q(core_q)
  );
  aud_icu_field #(.W(RST_W)) u_soft (
    .clk(clk), .rst_n(rst_n), .load(wsel[REG_SOFT]),
    .d(bus_wdata[RST_LSB +: RST_W]), .q(soft_q)
  );

  aud_icu_merge #(.N_SRC(N_SRC)) u_merge (
    .st  (st_q),
    .en_a(m1_q),
    .en_b(m2_q),
    .irq (irq_o)
  );

  // Read word assembly: fields spread back onto their bit positions.
  always_comb begin
    rd_word = '0;
    case (reg_idx_e'(idx))
      REG_STAT: for (int k = 0; k < N_SRC; k++) rd_word[k*SRC_STRIDE] = st_q[k];
      REG_EN1:  for (int k = 0; k < N_SRC; k++) rd_word[k*SRC_STRIDE] = m1_q[k];
      REG_EN2:  for (int k = 0; k < N_SRC; k++) rd_word[k*SRC_STRIDE] = m2_q[k];
      REG_MUTE: for (int k = 0; k < N_SRC; k++) rd_word[k*SRC_STRIDE] = mute_q[k];
      REG_CLK:  for (int c = 0; c < N_CLK; c++) rd_word[c*CLK_STRIDE] = clk_q[c];
      REG_SOFT: begin
        rd_word[0]                 = core_q;
        rd_word[RST_LSB +: RST_W]  = soft_q;
      end
      default:  rd_word = '0;
    endcase
    if (!hit) rd_word = '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      bus_rdata <= '0;
    else if (bus_rd) bus_rdata <= rd_word;
  end

  assign clk_run      = clk_q;
  assign core_run     = core_q;
  assign port_rst_ctl = soft_q;
  assign mute_o       = mute_q;

endmodule

// File: rtl/aud_icu_chk.sv
module aud_icu_chk (
  input logic        clk,
  input logic        rst_n,
  input logic [11:0] bus_addr,
  input logic        bus_wr,
  input logic [31:0] bus_wdata,
  input logic [3:0]  req_i,
  input logic        irq_o,
  input logic [1:0]  clk_run,
  input logic        core_run,
  input logic [3:0]  mute_o,
  input logic [3:0]  st_q,
  input logic [3:0]  m1_q,
  input logic [3:0]  m2_q,
  input logic [3:0]  soft_q
);

  logic in_win;
  assign in_win = (bus_addr[11:5] == 7'h10);

  AST_REQ_LATCHES: assert property (@(posedge clk) disable iff (!rst_n)
    (req_i != 4'b0) |=> ((st_q & $past(req_i)) == $past(req_i))); // R2

  AST_IRQ_NEEDS_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o |-> ((st_q != 4'b0) && (m1_q != 4'b0) && (m2_q != 4'b0))); // R3

  AST_ACK_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == 12'h214 && bus_wdata[4] && !soft_q[0] && req_i == 4'b0)
      |=> (st_q == 4'b0)); // R5

  AST_CLK_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == 12'h210)
      |=> (clk_run == {$past(bus_wdata[4]), $past(bus_wdata[0])})); // R6

  AST_OUTSIDE_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && !in_win) |=> ($stable(clk_run) && $stable(core_run) && $stable(mute_o))); // R8

endmodule

bind aud_icu aud_icu_chk u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .bus_addr (bus_addr),
  .bus_wr   (bus_wr),
  .bus_wdata(bus_wdata),
  .req_i    (req_i),
  .irq_o    (irq_o),
  .clk_run  (clk_run),
  .core_run (core_run),
  .mute_o   (mute_o),
  .st_q     (st_q),
  .m1_q     (m1_q),
  .m2_q     (m2_q),
  .soft_q   (soft_q)
);

// File: tb/sim_aud_icu.sv
module sim_aud_icu;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [11:0] bus_addr = '0;
  logic        bus_wr = 1'b0;
  logic        bus_rd = 1'b0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [3:0]  req_i = '0;
  logic        irq_o;
  logic [1:0]  clk_run;
  logic        core_run;
  logic [3:0]  port_rst_ctl;
  logic [3:0]  mute_o;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  logic [31:0] exp_q[$];
  string       tag_q[$];
  logic        rd_seen = 1'b0;

  always #2 clk = ~clk;  // 250 MHz

  aud_icu u0 (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_rd(bus_rd), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .req_i(req_i), .irq_o(irq_o), .clk_run(clk_run), .core_run(core_run),
    .port_rst_ctl(port_rst_ctl), .mute_o(mute_o)
  );

  task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s got=%h exp=%h", tag, got, exp);
    end
  endtask

  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  // Driver: issue a read and push the expected word for the monitor.
  task automatic rd(input logic [11:0] a, input logic [31:0] exp, input string tag);
    @(negedge clk);
    bus_addr = a; bus_rd = 1'b1;
    exp_q.push_back(exp);
    tag_q.push_back(tag);
    @(negedge clk);
    bus_rd = 1'b0;
  endtask

  task automatic pulse(input int k);
    @(negedge clk);
    req_i[k] = 1'b1;
    @(negedge clk);
    req_i[k] = 1'b0;
  endtask

  // Monitor: read data is registered on the edge that sees bus_rd (R9).
  always @(posedge clk) rd_seen <= bus_rd;
  always @(negedge clk) begin
    if (rd_seen) begin
      if (exp_q.size() == 0) begin
        checks++; errors++;
        $display("FAIL R9 unexpected read got=%h exp=none", bus_rdata);
      end else begin
        check(tag_q.pop_front(), bus_rdata, exp_q.pop_front());
      end
    end
  end

  task automatic finish_run();
    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog got=hung exp=done");
      finish_run();
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    check("R1 irq", 32'(irq_o), 0);
    check("R1 clk_run", 32'(clk_run), 0);
    check("R1 core_run", 32'(core_run), 0);
    check("R1 port_rst_ctl", 32'(port_rst_ctl), 0);
    check("R1 mute", 32'(mute_o), 0);
    rd(12'h200, 32'h0, "R1 status");
    rd(12'h214, 32'h0, "R1 soft");

    // R2 latching and bit positions
    pulse(0);
    rd(12'h200, 32'h0000_0001, "R2 A out bit0");
    check("R3 masked irq", 32'(irq_o), 0);
    pulse(3);
    rd(12'h200, 32'h0000_1001, "R2 B in bit12");

    // R3 both masks needed
    wr(12'h204, 32'h1);
    check("R3 one mask", 32'(irq_o), 0);
    wr(12'h208, 32'h1);
    check("R3 both masks", 32'(irq_o), 1);
    rd(12'h208, 32'h1, "R3 en2 readback");

    // R4 partial clear and race
    wr(12'h200, 32'h0000_1000);
    check("R4 irq after clear", 32'(irq_o), 0);
    rd(12'h200, 32'h0000_1000, "R4 partial keep");
    @(negedge clk); req_i[1] = 1'b1;
    wr(12'h200, 32'h0);
    req_i[1] = 1'b0;
    rd(12'h200, 32'h0000_0010, "R4 request wins");
    wr(12'h200, 32'h0);
    rd(12'h200, 32'h0, "R4 write zero");

    // R5 acknowledge via soft reset bit 4
    pulse(2);
    rd(12'h200, 32'h0000_0100, "R2 B out bit8");
    wr(12'h214, 32'h10);
    rd(12'h200, 32'h0, "R5 ack clears");
    rd(12'h214, 32'h10, "R7 soft readback");
    pulse(2);
    wr(12'h214, 32'h11);
    rd(12'h200, 32'h0000_0100, "R5 no ack when already high");
    check("R7 core_run", 32'(core_run), 1);
    wr(12'h214, 32'h01);
    wr(12'h214, 32'h11);
    rd(12'h200, 32'h0, "R5 fall then rise acks");

    // R7 port reset field
    wr(12'h214, 32'hA1);
    check("R7 port_rst_ctl", 32'(port_rst_ctl), 32'hA);
    check("R7 core_run kept", 32'(core_run), 1);

    // R6 clock release
    wr(12'h210, 32'h11);
    check("R6 both clocks", 32'(clk_run), 32'h3);
    wr(12'h210, 32'h10);
    check("R6 port B only", 32'(clk_run), 32'h2);

    // R10 mute
    wr(12'h20C, 32'h1010);
    check("R10 mute", 32'(mute_o), 32'hA);
    rd(12'h20C, 32'h1010, "R10 mute readback");

    // R8 outside window
    wr(12'h010, 32'hFFFF_FFFF);
    wr(12'h218, 32'hFFFF_FFFF);
    wr(12'h610, 32'hFFFF_FFFF);
    check("R8 clk_run kept", 32'(clk_run), 32'h2);
    check("R8 mute kept", 32'(mute_o), 32'hA);
    rd(12'h010, 32'h0, "R8 low read");
    rd(12'h218, 32'h0, "R8 past end read");
    rd(12'h610, 32'h0, "R8 alias read");
    rd(12'h210, 32'h10, "R8 clk reg intact");

    // R9 read data holds between reads
    repeat (3) @(negedge clk);
    check("R9 rdata held", bus_rdata, 32'h10);

    repeat (2) @(negedge clk);
    if (exp_q.size() != 0) begin
      checks++; errors++;
      $display("FAIL R9 pending reads got=%0d exp=0", exp_q.size());
    end
    finish_run();
  end

endmodule